// File: doc/BRIEF.md
# SPI FIFO Occupancy, Status and Interrupt Unit

This block sits between the register decoder of an SPI controller and its serial shift engine. It holds a transmit FIFO, which software fills and the shift engine drains, and a receive FIFO, which the shift engine fills and software drains. Around the two FIFOs it keeps the fill levels, software-programmed watermarks, a fixed-layout status word, sticky error flags with a write-to-clear register, an interrupt mask with a combined interrupt line, and two DMA request lines whose firing levels are programmable.

The register decoder drives one shared write-data bus plus a write strobe per register. It reads every register through a dedicated output. The shift engine sees a pop port with the transmit FIFO head and a push port into the receive FIFO, and it reports its busy state. All state changes on the rising clock edge. All read-side outputs are decoded from registered state, so an access is visible on the outputs from the cycle after it. The reset is asynchronous and active low. It is assumed to be released in step with the clock by the reset tree outside the block.

Top module: `spi_fifo_status_unit`

## Requirements
- R1: The transmit FIFO gives words to the engine in the order software pushed them. The receive FIFO gives words to software in the order the engine pushed them. Each level output reports the occupancy, from 0 to DEPTH (default 16). A push and a pop in the same cycle are both carried out. Whether a push finds the FIFO full is judged on the occupancy before that cycle's pop.
- R2: A software push into a full transmit FIFO is dropped and leaves the transmit level unchanged. It sets the sticky transmit-overflow interrupt bit (bit 1), which is visible from the next cycle.
- R3: A software pop from an empty receive FIFO returns zero on `rx_rdata` and sets the sticky receive-underflow bit (bit 2). An engine push into a full receive FIFO is dropped and sets the sticky receive-overflow bit (bit 3).
- R4: The status word carries the engine busy input at bit 0, transmit full at bit 1, transmit empty at bit 2, receive empty at bit 3 and receive full at bit 4.
- R5: Raw interrupt bit 0 is high while the transmit level is at or below the transmit watermark. Raw bit 4 is high while the receive level is above the receive watermark. Both are pure level conditions that the clear register cannot change.
- R6: The four threshold registers (transmit watermark, receive watermark, transmit DMA level, receive DMA level) store a written value only if it is below DEPTH. A write of DEPTH or more leaves the register unchanged. All four reset to 0.
- R7: A write to the clear register clears sticky bits as follows: data bit 0 clears all three, bit 1 clears receive underflow, bit 2 clears receive overflow, bit 3 clears transmit overflow. An error event in the same cycle as a clear of its bit leaves that bit set.
- R8: The masked interrupt word is the raw word ANDed with the 5-bit mask register, which resets to 0. `irq` is high when any masked bit is set.
- R9: In the DMA control register, bit 0 enables receive requests and bit 1 enables transmit requests. `dma_tx_req` is high when enabled and the transmit level is at or below the transmit DMA level. `dma_rx_req` is high when enabled and the receive level exceeds the receive DMA level.
- R10: An engine pop from an empty transmit FIFO has no effect and raises no interrupt bit. While the transmit FIFO is empty, `eng_tx_data` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wdata | input | CW | Shared write data for all register strobes |
| tx_wr | input | 1 | Software push into the transmit FIFO |
| tx_wdata | input | DW | Word pushed by software |
| rx_rd | input | 1 | Software pop from the receive FIFO |
| rx_rdata | output | DW | Receive FIFO head, zero when empty |
| tx_wm_we | input | 1 | Write the transmit watermark |
| rx_wm_we | input | 1 | Write the receive watermark |
| tx_dma_lvl_we | input | 1 | Write the transmit DMA level |
| rx_dma_lvl_we | input | 1 | Write the receive DMA level |
| mask_we | input | 1 | Write the interrupt mask |
| dma_ctl_we | input | 1 | Write the DMA enables |
| clr_we | input | 1 | Write the interrupt clear register |
| tx_level | output | LW | Transmit FIFO occupancy |
| rx_level | output | LW | Receive FIFO occupancy |
| tx_wm | output | TW | Transmit watermark |
| rx_wm | output | TW | Receive watermark |
| tx_dma_lvl | output | TW | Transmit DMA level |
| rx_dma_lvl | output | TW | Receive DMA level |
| irq_mask | output | 5 | Interrupt mask |
| dma_ctl | output | 2 | DMA enables |
| status | output | 5 | Status word |
| irq_raw | output | 5 | Raw interrupt word |
| irq_masked | output | 5 | Masked interrupt word |
| eng_busy | input | 1 | Engine is shifting |
| eng_tx_pop | input | 1 | Engine pops the transmit FIFO |
| eng_tx_data | output | DW | Transmit FIFO head, zero when empty |
| eng_rx_push | input | 1 | Engine pushes into the receive FIFO |
| eng_rx_data | input | DW | Word pushed by the engine |
| irq | output | 1 | Combined interrupt |
| dma_tx_req | output | 1 | Transmit DMA request |
| dma_rx_req | output | 1 | Receive DMA request |

## Verification
The hardest cases to reach from the ports are the same-cycle ones. One is a push into a full FIFO that coincides with a pop. The other is an error event landing in the cycle that clears its own sticky bit. Directed phases first fill and drain each FIFO past both ends. One of them issues a receive underflow together with a clear-all. A long random phase then toggles pushes, pops, clears and threshold writes, with write values on both sides of DEPTH, so that full-and-pop collisions and rejected threshold writes recur many times while the queue-based model follows every cycle.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int unsigned IRQ_W = 5;
  localparam int unsigned CLR_W = 4;
  localparam int unsigned DMA_W = 2;
  localparam int unsigned NTHR  = 4;

  // threshold register slots
  localparam int unsigned THR_TXWM  = 0;
  localparam int unsigned THR_RXWM  = 1;
  localparam int unsigned THR_TXDMA = 2;
  localparam int unsigned THR_RXDMA = 3;

  // clear register bits
  localparam int unsigned CLR_ALL = 0;
  localparam int unsigned CLR_RXU = 1;
  localparam int unsigned CLR_RXO = 2;
  localparam int unsigned CLR_TXO = 3;

  // DMA control bits
  localparam int unsigned DMA_RX_EN = 0;
  localparam int unsigned DMA_TX_EN = 1;

  // interrupt word, bit 4 down to bit 0
  typedef struct packed {
    logic rxf;
    logic rxo;
    logic rxu;
    logic txo;
    logic txe;
  } irq_vec_t;

  // status word, bit 4 down to bit 0
  typedef struct packed {
    logic rx_full;
    logic rx_empty;
    logic tx_empty;
    logic tx_full;
    logic busy;
  } stat_vec_t;
endpackage

// File: rtl/sfu_fifo.sv
module sfu_fifo #(
  parameter  int DEPTH = 16,
  parameter  int DW    = 16,
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int PW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          push_drop,
  output logic          pop_miss
);
  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LW-1:0] cnt_q, cnt_d;
  logic          push_ok, pop_ok;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (cnt_q == LW'(DEPTH));
  assign empty = (cnt_q == '0);

  always_comb begin
    push_ok   = push & ~full;
    pop_ok    = pop & ~empty;
    push_drop = push & full;
    pop_miss  = pop & empty;
    wptr_d    = push_ok ? ptr_inc(wptr_q) : wptr_q;
    rptr_d    = pop_ok ? ptr_inc(rptr_q) : rptr_q;
    cnt_d     = cnt_q + LW'(push_ok) - LW'(pop_ok);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= wptr_d;
      if (pop_ok)  rptr_q <= rptr_d;
      if (push_ok != pop_ok) cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr_q] <= wdata;
  end

  assign rdata = empty ? '0 : mem[rptr_q];
  assign level = cnt_q;

  // R1: occupancy never passes the depth
  assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LW'(DEPTH));

  // R2: a dropped push without a pop keeps the occupancy
  assert_drop_keeps_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/sfu_cfg.sv
module sfu_cfg
  import sfu_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int CW    = 8,
  localparam int TW    = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CW-1:0]            wdata,
  input  logic [NTHR-1:0]          thr_we,
  input  logic                     mask_we,
  input  logic                     dma_we,
  output logic [NTHR-1:0][TW-1:0]  thr_q,
  output logic [IRQ_W-1:0]         mask_q,
  output logic [DMA_W-1:0]         dma_q
);
  logic                    in_range;
  logic [IRQ_W-1:0]        mask_d;
  logic [DMA_W-1:0]        dma_d;

  assign in_range = (wdata < CW'(DEPTH));

  for (genvar g = 0; g < NTHR; g++) begin : g_thr
    logic          load;
    logic [TW-1:0] nxt;

    always_comb begin
      load = thr_we[g] & in_range;
      nxt  = load ? wdata[TW-1:0] : thr_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    thr_q[g] <= '0;
      else if (load) thr_q[g] <= nxt;
    end

    // R6: out-of-range writes do not alter the register
    assert_thr_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_we[g] && (wdata >= CW'(DEPTH))) |=> (thr_q[g] == $past(thr_q[g])));
  end

  always_comb begin
    mask_d = mask_we ? wdata[IRQ_W-1:0] : mask_q;
    dma_d  = dma_we ? wdata[DMA_W-1:0] : dma_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      dma_q  <= '0;
    end else begin
      if (mask_we) mask_q <= mask_d;
      if (dma_we)  dma_q  <= dma_d;
    end
  end
endmodule

// File: rtl/sfu_irq.sv
module sfu_irq
  import sfu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_txo,
  input  logic             ev_rxu,
  input  logic             ev_rxo,
  input  logic             txe_lvl,
  input  logic             rxf_lvl,
  input  logic             clr_we,
  input  logic [CLR_W-1:0] clr_bits,
  input  logic [IRQ_W-1:0] mask,
  output irq_vec_t         raw,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);
  logic txo_q, rxu_q, rxo_q;
  logic txo_d, rxu_d, rxo_d;
  logic [CLR_W-1:0] clr;

  always_comb begin
    clr   = clr_we ? clr_bits : '0;
    txo_d = ev_txo | (txo_q & ~(clr[CLR_ALL] | clr[CLR_TXO]));
    rxu_d = ev_rxu | (rxu_q & ~(clr[CLR_ALL] | clr[CLR_RXU]));
    rxo_d = ev_rxo | (rxo_q & ~(clr[CLR_ALL] | clr[CLR_RXO]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txo_q <= 1'b0;
      rxu_q <= 1'b0;
      rxo_q <= 1'b0;
    end else begin
      txo_q <= txo_d;
      rxu_q <= rxu_d;
      rxo_q <= rxo_d;
    end
  end

  always_comb begin
    raw.rxf = rxf_lvl;
    raw.rxo = rxo_q;
    raw.rxu = rxu_q;
    raw.txo = txo_q;
    raw.txe = txe_lvl;
    masked  = raw & mask;
    irq     = |masked;
  end

  // R7: clear-all with no new event empties every sticky bit
  assert_clear_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[CLR_ALL] && !ev_txo && !ev_rxu && !ev_rxo)
      |=> !(raw.txo || raw.rxu || raw.rxo));

  // R2: a dropped transmit push is always recorded
  assert_txo_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_txo |=> raw.txo);

  // R3: an empty receive pop is always recorded
  assert_rxu_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rxu |=> raw.rxu);
endmodule

// File: rtl/spi_fifo_status_unit.sv
module spi_fifo_status_unit
  import sfu_pkg::*;
#(
  parameter  int DEPTH = 16,
  parameter  int DW    = 16,
  parameter  int CW    = 8,
  localparam int LW    = $clog2(DEPTH + 1),
  localparam int TW    = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    reg_wdata,
  input  logic             tx_wr,
  input  logic [DW-1:0]    tx_wdata,
  input  logic             rx_rd,
  output logic [DW-1:0]    rx_rdata,
  input  logic             tx_wm_we,
  input  logic             rx_wm_we,
  input  logic             tx_dma_lvl_we,
  input  logic             rx_dma_lvl_we,
  input  logic             mask_we,
  input  logic             dma_ctl_we,
  input  logic             clr_we,
  output logic [LW-1:0]    tx_level,
  output logic [LW-1:0]    rx_level,
  output logic [TW-1:0]    tx_wm,
  output logic [TW-1:0]    rx_wm,
  output logic [TW-1:0]    tx_dma_lvl,
  output logic [TW-1:0]    rx_dma_lvl,
  output logic [IRQ_W-1:0] irq_mask,
  output logic [DMA_W-1:0] dma_ctl,
  output logic [IRQ_W-1:0] status,
  output logic [IRQ_W-1:0] irq_raw,
  output logic [IRQ_W-1:0] irq_masked,
  input  logic             eng_busy,
  input  logic             eng_tx_pop,
  output logic [DW-1:0]    eng_tx_data,
  input  logic             eng_rx_push,
  input  logic [DW-1:0]    eng_rx_data,
  output logic             irq,
  output logic             dma_tx_req,
  output logic             dma_rx_req
);
  logic tx_full, tx_empty, tx_drop, tx_miss;
  logic rx_full, rx_empty, rx_drop, rx_miss;
  logic [NTHR-1:0][TW-1:0] thr;
  logic [NTHR-1:0]         thr_we;
  logic                    txe_lvl, rxf_lvl;
  irq_vec_t                raw;
  stat_vec_t               st;

  sfu_fifo #(.DEPTH(DEPTH), .DW(DW)) u_txf (
    .clk(clk), .rst_n(rst_n),
    .push(tx_wr), .wdata(tx_wdata),
    .pop(eng_tx_pop), .rdata(eng_tx_data),
    .level(tx_level), .full(tx_full), .empty(tx_empty),
    .push_drop(tx_drop), .pop_miss(tx_miss)
  );

  sfu_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rxf (
    .clk(clk), .rst_n(rst_n),
    .push(eng_rx_push), .wdata(eng_rx_data),
    .pop(rx_rd), .rdata(rx_rdata),
    .level(rx_level), .full(rx_full), .empty(rx_empty),
    .push_drop(rx_drop), .pop_miss(rx_miss)
  );

  always_comb begin
    thr_we            = '0;
    thr_we[THR_TXWM]  = tx_wm_we;
    thr_we[THR_RXWM]  = rx_wm_we;
    thr_we[THR_TXDMA] = tx_dma_lvl_we;
    thr_we[THR_RXDMA] = rx_dma_lvl_we;
  end

  sfu_cfg #(.DEPTH(DEPTH), .CW(CW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wdata(reg_wdata),
    .thr_we(thr_we), .mask_we(mask_we), .dma_we(dma_ctl_we),
    .thr_q(thr), .mask_q(irq_mask), .dma_q(dma_ctl)
  );

  assign tx_wm      = thr[THR_TXWM];
  assign rx_wm      = thr[THR_RXWM];
  assign tx_dma_lvl = thr[THR_TXDMA];
  assign rx_dma_lvl = thr[THR_RXDMA];

  assign txe_lvl = (tx_level <= LW'(tx_wm));
  assign rxf_lvl = (rx_level >  LW'(rx_wm));

  sfu_irq u_irq (
    .clk(clk), .rst_n(rst_n),
    .ev_txo(tx_drop), .ev_rxu(rx_miss), .ev_rxo(rx_drop),
    .txe_lvl(txe_lvl), .rxf_lvl(rxf_lvl),
    .clr_we(clr_we), .clr_bits(reg_wdata[CLR_W-1:0]),
    .mask(irq_mask), .raw(raw), .masked(irq_masked), .irq(irq)
  );

  assign irq_raw = raw;

  always_comb begin
    st.busy     = eng_busy;
    st.tx_full  = tx_full;
    st.tx_empty = tx_empty;
    st.rx_empty = rx_empty;
    st.rx_full  = rx_full;
    status      = st;
  end

  assign dma_tx_req = dma_ctl[DMA_TX_EN] & (tx_level <= LW'(tx_dma_lvl));
  assign dma_rx_req = dma_ctl[DMA_RX_EN] & (rx_level >  LW'(rx_dma_lvl));

  // R10: an engine pop on an empty transmit FIFO leaves it empty
  assert_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_miss && !tx_wr) |=> (tx_level == '0));
endmodule

// File: tb/sim_spi_fifo_status_unit.sv
module sim_spi_fifo_status_unit;
  localparam int D = 16;

  logic        clk, rst_n;
  logic [7:0]  reg_wdata;
  logic        tx_wr, rx_rd, tx_wm_we, rx_wm_we, tx_dma_lvl_we, rx_dma_lvl_we;
  logic        mask_we, dma_ctl_we, clr_we, eng_busy, eng_tx_pop, eng_rx_push;
  logic [15:0] tx_wdata, eng_rx_data, rx_rdata, eng_tx_data;
  logic [4:0]  tx_level, rx_level;
  logic [3:0]  tx_wm, rx_wm, tx_dma_lvl, rx_dma_lvl;
  logic [4:0]  irq_mask, status, irq_raw, irq_masked;
  logic [1:0]  dma_ctl;
  logic        irq, dma_tx_req, dma_rx_req;

  spi_fifo_status_unit u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  logic [15:0] txq[$], rxq[$];
  int  m_txwm, m_rxwm, m_txd, m_rxd;
  bit  [4:0] m_mask;
  bit  [1:0] m_dma;
  bit  m_txo, m_rxu, m_rxo;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit [4:0] exp_raw();
    bit [4:0] r;
    r[0] = (txq.size() <= m_txwm);
    r[1] = m_txo;
    r[2] = m_rxu;
    r[3] = m_rxo;
    r[4] = (rxq.size() > m_rxwm);
    return r;
  endfunction

  task automatic compare();
    bit [4:0] r, s;
    r = exp_raw();
    s = {rxq.size() == D, rxq.size() == 0, txq.size() == 0, txq.size() == D, eng_busy};
    chk("R1 tx_level", tx_level, txq.size());
    chk("R1 rx_level", rx_level, rxq.size());
    if (txq.size() > 0) chk("R1 eng_tx_data order", eng_tx_data, txq[0]);
    else                chk("R10 eng_tx_data empty", eng_tx_data, 0);
    if (rxq.size() > 0) chk("R1 rx_rdata order", rx_rdata, rxq[0]);
    else                chk("R3 rx_rdata empty", rx_rdata, 0);
    chk("R4 status", status, s);
    chk("R5 level irq bits", irq_raw & 5'h11, r & 5'h11);
    chk("R2 txo sticky", irq_raw[1], r[1]);
    chk("R3 rxu/rxo sticky", irq_raw[3:2], r[3:2]);
    chk("R6 tx_wm", tx_wm, m_txwm);
    chk("R6 rx_wm", rx_wm, m_rxwm);
    chk("R6 tx_dma_lvl", tx_dma_lvl, m_txd);
    chk("R6 rx_dma_lvl", rx_dma_lvl, m_rxd);
    chk("R8 irq_mask", irq_mask, m_mask);
    chk("R8 irq_masked", irq_masked, r & m_mask);
    chk("R8 irq", irq, |(r & m_mask));
    chk("R9 dma_ctl", dma_ctl, m_dma);
    chk("R9 dma_tx_req", dma_tx_req, m_dma[1] && (txq.size() <= m_txd));
    chk("R9 dma_rx_req", dma_rx_req, m_dma[0] && (rxq.size() > m_rxd));
  endtask

  task automatic model_update();
    bit ev_txo, ev_rxu, ev_rxo, t_push, t_pop, r_push, r_pop;
    bit [3:0] c;
    ev_txo = tx_wr && txq.size() == D;
    t_push = tx_wr && txq.size() < D;
    t_pop  = eng_tx_pop && txq.size() > 0;
    ev_rxo = eng_rx_push && rxq.size() == D;
    r_push = eng_rx_push && rxq.size() < D;
    r_pop  = rx_rd && rxq.size() > 0;
    ev_rxu = rx_rd && rxq.size() == 0;
    if (t_pop)  void'(txq.pop_front());
    if (t_push) txq.push_back(tx_wdata);
    if (r_pop)  void'(rxq.pop_front());
    if (r_push) rxq.push_back(eng_rx_data);
    c = clr_we ? reg_wdata[3:0] : 4'h0;
    m_txo = ev_txo | (m_txo & !(c[0] | c[3]));
    m_rxu = ev_rxu | (m_rxu & !(c[0] | c[1]));
    m_rxo = ev_rxo | (m_rxo & !(c[0] | c[2]));
    if (tx_wm_we && reg_wdata < D)      m_txwm = reg_wdata;
    if (rx_wm_we && reg_wdata < D)      m_rxwm = reg_wdata;
    if (tx_dma_lvl_we && reg_wdata < D) m_txd = reg_wdata;
    if (rx_dma_lvl_we && reg_wdata < D) m_rxd = reg_wdata;
    if (mask_we)    m_mask = reg_wdata[4:0];
    if (dma_ctl_we) m_dma  = reg_wdata[1:0];
  endtask

  task automatic clear_strobes();
    tx_wr = 0; rx_rd = 0; tx_wm_we = 0; rx_wm_we = 0; tx_dma_lvl_we = 0;
    rx_dma_lvl_we = 0; mask_we = 0; dma_ctl_we = 0; clr_we = 0;
    eng_tx_pop = 0; eng_rx_push = 0;
  endtask

  // inputs are set after a falling edge; one rising edge; compare at the next falling edge
  task automatic tick();
    @(posedge clk);
    model_update();
    @(negedge clk);
    compare();
    clear_strobes();
  endtask

  task automatic wr_reg(input int which, input int val);
    reg_wdata = 8'(val);
    case (which)
      0: tx_wm_we = 1;
      1: rx_wm_we = 1;
      2: tx_dma_lvl_we = 1;
      3: rx_dma_lvl_we = 1;
      4: mask_we = 1;
      5: dma_ctl_we = 1;
      default: clr_we = 1;
    endcase
    tick();
  endtask

  initial begin
    rst_n = 0; reg_wdata = 0; tx_wdata = 0; eng_rx_data = 0; eng_busy = 0;
    clear_strobes();
    m_txwm = 0; m_rxwm = 0; m_txd = 0; m_rxd = 0; m_mask = 0; m_dma = 0;
    m_txo = 0; m_rxu = 0; m_rxo = 0;
    repeat (3) @(negedge clk);
    compare();                                  // reset state, all requirements
    rst_n = 1;
    @(negedge clk);
    compare();

    // R1/R2: fill the transmit FIFO past full
    for (int i = 0; i < 20; i++) begin
      tx_wr = 1; tx_wdata = 16'(i * 16'h0111 + 5);
      tick();
    end
    chk("R2 txo after overflow", irq_raw[1], 1);
    chk("R2 level held at depth", tx_level, D);

    // R1/R10: drain it through the engine and beyond empty
    eng_busy = 1;
    for (int i = 0; i < 18; i++) begin
      eng_tx_pop = 1;
      tick();
    end
    chk("R10 no flag on empty pop", irq_raw[3:1] & 3'b110, 3'b000);

    // R1/R3: engine fills the receive FIFO past full; software drains past empty
    for (int i = 0; i < 18; i++) begin
      eng_rx_push = 1; eng_rx_data = 16'(16'hA000 + i);
      tick();
    end
    chk("R3 rxo after overflow", irq_raw[3], 1);
    for (int i = 0; i < 18; i++) begin
      rx_rd = 1;
      tick();
    end
    chk("R3 rxu after underflow", irq_raw[2], 1);
    eng_busy = 0;

    // R6: threshold writes around the depth
    wr_reg(0, 16);  chk("R6 tx_wm reject 16", tx_wm, 0);
    wr_reg(0, 15);  chk("R6 tx_wm accept 15", tx_wm, 15);
    wr_reg(0, 200); chk("R6 tx_wm reject 200", tx_wm, 15);
    wr_reg(1, 7);
    wr_reg(2, 3);
    wr_reg(3, 5);
    wr_reg(4, 31);
    wr_reg(5, 3);

    // R7: selective clears
    wr_reg(6, 4'h8); chk("R7 clear txo only", irq_raw[3:1], 3'b110);
    wr_reg(6, 4'h2); chk("R7 clear rxu only", irq_raw[3:1], 3'b100);
    wr_reg(6, 4'h1); chk("R7 clear all", irq_raw[3:1], 3'b000);
    // event and clear in the same cycle: the event wins
    rx_rd = 1; reg_wdata = 8'h1; clr_we = 1;
    tick();
    chk("R7 event beats clear", irq_raw[2], 1);
    wr_reg(6, 4'h4); chk("R7 rxo clear keeps rxu", irq_raw[2], 1);
    wr_reg(6, 4'h2); chk("R7 rxu cleared", irq_raw[2], 0);
    chk("R5 txe level not clearable", irq_raw[0], 1);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int sel;
      tx_wr       = 1'($urandom_range(0, 1));
      tx_wdata    = 16'($urandom);
      eng_tx_pop  = 1'($urandom_range(0, 1));
      eng_rx_push = 1'($urandom_range(0, 1));
      eng_rx_data = 16'($urandom);
      rx_rd       = 1'($urandom_range(0, 1));
      eng_busy    = 1'($urandom_range(0, 1));
      sel = $urandom_range(0, 15);
      reg_wdata = ($urandom_range(0, 7) == 0) ? 8'($urandom) : 8'($urandom_range(0, 20));
      case (sel)
        0: tx_wm_we = 1;
        1: rx_wm_we = 1;
        2: tx_dma_lvl_we = 1;
        3: rx_dma_lvl_we = 1;
        4: mask_we = 1;
        5: dma_ctl_we = 1;
        6, 7: clr_we = 1;
        default: ;
      endcase
      tick();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule